// File: doc/BRIEF.md
# Staggered-Load Bit-Serial Multiply-Accumulate Array

This block is a grid of bit-serial inner-product cells arranged in `ROWS` rows and `COLS` columns. Every cell holds `LANES` one-bit weight registers. Each cycle it ANDs them with `LANES` activation bits, counts the ones, and adds that count, shifted by the current bit significance, into its own accumulator. Each row has one weight-bit bus that all cells of the row share. Each column has one activation-bit bus that all cells of the column share. Both operands are unsigned and enter least significant bit first. Each weight bit stays in the weight registers while every activation bit position is applied to it. Then the next weight bit is loaded.

A controller sequences the cells in one of two modes, chosen at layer start. In the dense mode (fully-connected layers) every column works on its own weight set. Column c starts one cycle after column c-1. The row weight bus therefore serves one column per cycle, and each column keeps reusing its held bit while the other columns load. In the window mode (convolutional layers) all columns latch the same weight bits together, and each column works on the activations of a different window. Each column runs a programmed number of jobs back to back. A per-column strobe marks every finished result.

Top module: `serialMacArray`

## Requirements
- R1: After reset `outValid` is all zero and every result field of `outData` is zero.
- R2: A finished result of cell (r,c) equals the sum over its lanes of W*A. W is the `wPrec`-bit weight whose bit j drives row bus bit `r*LANES+l` in that column's load step for bit j. A is the `aPrec`-bit activation whose bit i drives column bus bit `c*LANES+l` in step i of each weight-bit period. The result sits in `outData[(r*COLS+c)*ACCW +: ACCW]`, with ACCW = 32 + clog2(LANES+1).
- R3: In dense mode (`modeConv`=0) the period spent on one weight bit is H = max(`aPrec`, COLS) steps. Column c takes its first step in cycle c, where cycle 0 is the cycle that starts at the clock edge that accepts `start`. A column loads weight bit j at step j*H of a job, so no two columns load in the same cycle.
- R4: The bus values of a column's last job step in cycle k produce `outValid[c]`=1 during cycle k+2. A job spans `wPrec`*H cycles.
- R5: In window mode (`modeConv`=1) H = `aPrec`. All columns step from cycle 0 in lockstep, every column latches the row weight bits in the same cycle, and each column uses its own activation bus.
- R6: A column ignores the row weight bus on every step that is not a load step. In dense mode it ignores its activation bits on steps i >= `aPrec` within a weight-bit period.
- R7: `wPrec`, `aPrec` (each 1 to 16), `modeConv` and `jobCount` are captured only when `start` is high while no column has jobs left. A `start` during a layer and any later changes on these ports have no effect.
- R8: Each column runs `jobCount` jobs with no idle cycle between them. A `jobCount` of zero produces no result.
- R9: `outValid[c]` is high for one cycle per finished job, and `outData` keeps the last result until the next one.
- R10: With both precisions at 16 and all operand bits set, the result is LANES*(2^16-1)^2 without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a layer with the settings on the ports below |
| modeConv | input | 1 | 1 = window mode, 0 = dense staggered mode |
| wPrec | input | 5 | Weight precision in bits, 1 to 16 |
| aPrec | input | 5 | Activation precision in bits, 1 to 16 |
| jobCount | input | JOBW (8) | Jobs per column in this layer |
| wBus | input | ROWS*LANES (8) | Weight-bit bus, row r lane l at bit r*LANES+l |
| aBus | input | COLS*LANES (16) | Activation-bit bus, column c lane l at bit c*LANES+l |
| outData | output | ROWS*COLS*ACCW (280) | Result of cell (r,c) at bits (r*COLS+c)*ACCW upward |
| outValid | output | COLS (4) | One-cycle strobe per finished column result |

## Verification
The assertions check the structural rules on every cycle. In dense mode at most one column loads per cycle, and in window mode all columns step and load together. A column's valid strobe only follows a last step two cycles earlier. Settings stay put when a start arrives during a layer, and the shift applied to a partial sum never exceeds the sum of the two precisions minus two. Only the bench scenarios can show that the arithmetic is right. They cover the exact result cycle of each staggered column, the masking of padded activation steps and idle weight-bus cycles, back-to-back one-bit jobs, a zero job count and full 16-bit operands.

// File: rtl/serialMacPkg.sv
package serialMacPkg;

  localparam int MAX_PREC = 16;
  localparam int PREC_W   = $clog2(MAX_PREC + 1);
  localparam int SHIFT_W  = $clog2(2 * MAX_PREC - 1);

  // Per-column control strobes from the sequencer to the datapath
  typedef struct packed {
    logic               step;   // column consumes bus bits this cycle
    logic               load;   // latch weight bits from the row bus
    logic               actEn;  // activation position within precision
    logic               first;  // first step of a job
    logic               last;   // last step of a job
    logic [SHIFT_W-1:0] shamt;  // significance of the partial sum
  } colStrobe_t;

endpackage

// File: rtl/serialMacCell.sv
module serialMacCell
  import serialMacPkg::*;
#(
  parameter int LANES = 4,
  parameter int ACCW  = 35
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strobe,
  input  logic [LANES-1:0] wBits,
  input  logic [LANES-1:0] aBits,
  output logic [ACCW-1:0]  result,
  output logic             resultValid
);

  localparam int SUMW = $clog2(LANES + 1);

  logic [LANES-1:0]   wReg;
  logic [LANES-1:0]   effW;
  logic [LANES-1:0]   effA;
  logic [SUMW-1:0]    laneSum;

  logic               s1Valid;
  logic               s1First;
  logic               s1Last;
  logic [SUMW-1:0]    s1Sum;
  logic [SHIFT_W-1:0] s1Shamt;

  logic [ACCW-1:0]    accQ;
  logic [ACCW-1:0]    term;
  logic [ACCW-1:0]    accSum;

  // A freshly loaded weight bit is used in the same step
  assign effW = strobe.load ? wBits : wReg;
  assign effA = strobe.actEn ? aBits : '0;

  always_comb begin
    laneSum = '0;
    for (int l = 0; l < LANES; l++) begin
      laneSum = laneSum + SUMW'(effW[l] & effA[l]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wReg <= '0;
    end else if (strobe.step && strobe.load) begin
      wReg <= wBits;
    end
  end

  // Stage 1: registered product count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1First <= 1'b0;
      s1Last  <= 1'b0;
      s1Sum   <= '0;
      s1Shamt <= '0;
    end else begin
      s1Valid <= strobe.step;
      s1First <= strobe.first;
      s1Last  <= strobe.last;
      s1Sum   <= laneSum;
      s1Shamt <= strobe.shamt;
    end
  end

  assign term   = ACCW'(s1Sum) << s1Shamt;
  assign accSum = (s1First ? '0 : accQ) + term;

  // Stage 2: shifted accumulation and result capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ        <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= s1Valid && s1Last;
      if (s1Valid) begin
        accQ <= accSum;
        if (s1Last) begin
          result <= accSum;
        end
      end
    end
  end

endmodule

// File: rtl/serialMacPath.sv
module serialMacPath
  import serialMacPkg::*;
#(
  parameter int ROWS  = 2,
  parameter int COLS  = 4,
  parameter int LANES = 4,
  parameter int ACCW  = 35
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  colStrobe_t [COLS-1:0]      strobes,
  input  logic [ROWS*LANES-1:0]      wBus,
  input  logic [COLS*LANES-1:0]      aBus,
  output logic [ROWS*COLS*ACCW-1:0]  outData,
  output logic [COLS-1:0]            outValid
);

  logic [COLS-1:0][ROWS-1:0] cellValid;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      serialMacCell #(
        .LANES (LANES),
        .ACCW  (ACCW)
      ) i_cell (
        .clk         (clk),
        .rstN        (rstN),
        .strobe      (strobes[c]),
        .wBits       (wBus[r*LANES +: LANES]),
        .aBits       (aBus[c*LANES +: LANES]),
        .result      (outData[(r*COLS+c)*ACCW +: ACCW]),
        .resultValid (cellValid[c][r])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_valid
    assign outValid[c] = &cellValid[c];

    // R4: a strobe is the registered outcome of a last step two cycles back
    p_valid_after_last_r4 : assert property (@(posedge clk) disable iff (!rstN)
      outValid[c] |-> $past(strobes[c].step && strobes[c].last, 2));

    // R5: all cells of a column finish together
    p_rows_agree_r5 : assert property (@(posedge clk) disable iff (!rstN)
      (cellValid[c] == '0) || (cellValid[c] == '1));
  end

endmodule

// File: rtl/serialMacCtrl.sv
module serialMacCtrl
  import serialMacPkg::*;
#(
  parameter int COLS = 4,
  parameter int JOBW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  modeConv,
  input  logic [PREC_W-1:0]     wPrecIn,
  input  logic [PREC_W-1:0]     aPrecIn,
  input  logic [JOBW-1:0]       jobCount,
  output colStrobe_t [COLS-1:0] strobes
);

  localparam int HOLD_MAX = (COLS > MAX_PREC) ? COLS : MAX_PREC;
  localparam int HW       = $clog2(HOLD_MAX + 1);
  localparam int DW       = $clog2(COLS + 1);

  logic              modeQ;
  logic [PREC_W-1:0] wPrecQ;
  logic [PREC_W-1:0] aPrecQ;
  logic [HW-1:0]     holdQ;
  logic [HW-1:0]     holdNext;
  logic [HW-1:0]     aExt;

  logic [COLS-1:0]   colBusy;
  logic [COLS-1:0]   stepVec;
  logic [COLS-1:0]   loadVec;
  logic              busy;
  logic              accept;

  assign busy   = |colBusy;
  assign accept = start && !busy;
  assign aExt   = HW'(aPrecIn);

  // Dense mode pads the weight-bit period up to the column count
  always_comb begin
    if (modeConv) begin
      holdNext = aExt;
    end else begin
      holdNext = (aExt > HW'(COLS)) ? aExt : HW'(COLS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      wPrecQ <= PREC_W'(1);
      aPrecQ <= PREC_W'(1);
      holdQ  <= HW'(1);
    end else if (accept) begin
      modeQ  <= modeConv;
      wPrecQ <= wPrecIn;
      aPrecQ <= aPrecIn;
      holdQ  <= holdNext;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [DW-1:0]     delayQ;
    logic [HW-1:0]     iCntQ;
    logic [PREC_W-1:0] jCntQ;
    logic [JOBW-1:0]   jobLeftQ;
    logic              endAct;
    logic              endW;
    colStrobe_t        sc;

    assign colBusy[c] = (jobLeftQ != '0);
    assign stepVec[c] = colBusy[c] && (delayQ == '0);
    assign endAct     = (iCntQ == holdQ - HW'(1));
    assign endW       = (jCntQ == wPrecQ - PREC_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        delayQ   <= '0;
        iCntQ    <= '0;
        jCntQ    <= '0;
        jobLeftQ <= '0;
      end else if (accept) begin
        delayQ   <= modeConv ? '0 : DW'(c);
        iCntQ    <= '0;
        jCntQ    <= '0;
        jobLeftQ <= jobCount;
      end else if (colBusy[c]) begin
        if (delayQ != '0) begin
          delayQ <= delayQ - DW'(1);
        end else if (endAct) begin
          iCntQ <= '0;
          if (endW) begin
            jCntQ    <= '0;
            jobLeftQ <= jobLeftQ - JOBW'(1);
          end else begin
            jCntQ <= jCntQ + PREC_W'(1);
          end
        end else begin
          iCntQ <= iCntQ + HW'(1);
        end
      end
    end

    always_comb begin
      sc.step  = stepVec[c];
      sc.load  = (iCntQ == '0);
      sc.actEn = (iCntQ < HW'(aPrecQ));
      sc.first = (iCntQ == '0) && (jCntQ == '0);
      sc.last  = endAct && endW;
      sc.shamt = SHIFT_W'(iCntQ) + SHIFT_W'(jCntQ);
    end

    assign strobes[c] = sc;
    assign loadVec[c] = stepVec[c] && sc.load;

    // R2: partial sums never land above the top product bit
    p_shift_bound_r2 : assert property (@(posedge clk) disable iff (!rstN)
      (stepVec[c] && sc.actEn) |->
        (int'(sc.shamt) <= int'(wPrecQ) + int'(aPrecQ) - 2));
  end

  // R3: the staggered start keeps the shared weight bus to one column
  p_one_load_r3 : assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> $onehot0(loadVec));

  // R5: window mode steps and loads every column together
  p_lockstep_r5 : assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> ((stepVec == '0) || (stepVec == '1)) &&
              ((loadVec == '0) || (loadVec == '1)));

  // R7: settings are frozen while a layer is in flight
  p_start_ignored_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(wPrecQ) && $stable(aPrecQ) &&
                         $stable(modeQ) && $stable(holdQ)));

endmodule

// File: rtl/serialMacArray.sv
module serialMacArray
  import serialMacPkg::*;
#(
  parameter int ROWS  = 2,
  parameter int COLS  = 4,
  parameter int LANES = 4,
  parameter int JOBW  = 8,
  localparam int ACCW = 2 * MAX_PREC + $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      modeConv,
  input  logic [PREC_W-1:0]         wPrec,
  input  logic [PREC_W-1:0]         aPrec,
  input  logic [JOBW-1:0]           jobCount,
  input  logic [ROWS*LANES-1:0]     wBus,
  input  logic [COLS*LANES-1:0]     aBus,
  output logic [ROWS*COLS*ACCW-1:0] outData,
  output logic [COLS-1:0]           outValid
);

  colStrobe_t [COLS-1:0] strobes;

  serialMacCtrl #(
    .COLS (COLS),
    .JOBW (JOBW)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeConv (modeConv),
    .wPrecIn  (wPrec),
    .aPrecIn  (aPrec),
    .jobCount (jobCount),
    .strobes  (strobes)
  );

  serialMacPath #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .LANES (LANES),
    .ACCW  (ACCW)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wBus     (wBus),
    .aBus     (aBus),
    .outData  (outData),
    .outValid (outValid)
  );

endmodule

// File: tb/test_serialMacArray.sv
module test_serialMacArray;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 2;
  localparam int COLS  = 4;
  localparam int LANES = 4;
  localparam int JOBW  = 8;
  localparam int ACCW  = 32 + $clog2(LANES + 1);
  localparam int MAXJ  = 4;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      start = 1'b0;
  logic                      modeConv = 1'b0;
  logic [4:0]                wPrec = 5'd1;
  logic [4:0]                aPrec = 5'd1;
  logic [JOBW-1:0]           jobCount = '0;
  logic [ROWS*LANES-1:0]     wBus = '0;
  logic [COLS*LANES-1:0]     aBus = '0;
  logic [ROWS*COLS*ACCW-1:0] outData;
  logic [COLS-1:0]           outValid;

  int total = 0;
  int bad   = 0;

  int unsigned wSet [COLS][MAXJ][ROWS][LANES];
  int unsigned aSet [COLS][MAXJ][LANES];
  logic [63:0] expRes [COLS][MAXJ][ROWS];
  logic [63:0] lastExp [ROWS][COLS];

  always #(CLK_PERIOD/2) clk = ~clk;

  serialMacArray #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .LANES (LANES),
    .JOBW  (JOBW)
  ) i_serialMacArray (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeConv (modeConv),
    .wPrec    (wPrec),
    .aPrec    (aPrec),
    .jobCount (jobCount),
    .wBus     (wBus),
    .aBus     (aBus),
    .outData  (outData),
    .outValid (outValid)
  );

  task automatic checkCycle(input int k, input bit conv, input int jobs,
                            input int len, input string tag);
    for (int c = 0; c < COLS; c++) begin
      int  o;
      int  s;
      bit  expV;
      o = conv ? 0 : c;
      s = k - 2 - o;
      expV = (jobs > 0) && (s >= 0) && (s < jobs * len) && ((s % len) == len - 1);
      if (expV) begin
        for (int r = 0; r < ROWS; r++) lastExp[r][c] = expRes[c][s / len][r];
      end
      total++;
      if (outValid[c] !== expV) begin
        bad++;
        $display("FAIL R4 %s cycle %0d col %0d valid: actual=%0b expected=%0b",
                 tag, k, c, outValid[c], expV);
      end
      for (int r = 0; r < ROWS; r++) begin
        logic [ACCW-1:0] got;
        logic [ACCW-1:0] exp;
        got = outData[(r*COLS+c)*ACCW +: ACCW];
        exp = lastExp[r][c][ACCW-1:0];
        total++;
        if (got !== exp) begin
          bad++;
          $display("FAIL R2 R9 %s cycle %0d cell %0d,%0d data: actual=%0d expected=%0d",
                   tag, k, r, c, got, exp);
        end
      end
    end
  endtask

  task automatic driveCycle(input int k, input bit conv, input int pw, input int pa,
                            input int jobs, input int hold, input bit garbage);
    logic [ROWS*LANES-1:0] wv;
    logic [COLS*LANES-1:0] av;
    int len;
    len = pw * hold;
    wv = garbage ? ROWS*LANES'($urandom) : '0;
    av = garbage ? COLS*LANES'($urandom) : '0;
    for (int c = 0; c < COLS; c++) begin
      int o;
      int s;
      o = conv ? 0 : c;
      s = k - o;
      if (s >= 0 && s < jobs * len) begin
        int n;
        int t;
        int j;
        int i;
        n = s / len;
        t = s % len;
        j = t / hold;
        i = t % hold;
        for (int l = 0; l < LANES; l++) begin
          if (i < pa) av[c*LANES+l] = aSet[c][n][l][i];
        end
        if (i == 0) begin
          for (int r = 0; r < ROWS; r++)
            for (int l = 0; l < LANES; l++)
              wv[r*LANES+l] = wSet[c][n][r][l][j];
        end
      end
    end
    wBus = wv;
    aBus = av;
  endtask

  task automatic runLayer(input bit conv, input int pw, input int pa, input int jobs,
                          input bit garbage, input bit disturb, input bit allOnes,
                          input string tag);
    int hold;
    int len;
    int lastK;
    int unsigned wm;
    int unsigned am;
    wm = (32'd1 << pw) - 1;
    am = (32'd1 << pa) - 1;
    for (int n = 0; n < MAXJ; n++) begin
      for (int c = 0; c < COLS; c++) begin
        for (int l = 0; l < LANES; l++) aSet[c][n][l] = allOnes ? am : ($urandom & am);
        for (int r = 0; r < ROWS; r++)
          for (int l = 0; l < LANES; l++)
            wSet[c][n][r][l] = (conv && c > 0) ? wSet[0][n][r][l] :
                               (allOnes ? wm : ($urandom & wm));
      end
      for (int c = 0; c < COLS; c++)
        for (int r = 0; r < ROWS; r++) begin
          logic [63:0] acc;
          acc = '0;
          for (int l = 0; l < LANES; l++)
            acc += 64'(wSet[c][n][r][l]) * 64'(aSet[c][n][l]);
          expRes[c][n][r] = acc;
        end
    end
    hold = conv ? pa : ((pa > COLS) ? pa : COLS);
    len  = pw * hold;
    lastK = (jobs == 0) ? 8 : ((conv ? 0 : COLS - 1) + jobs * len + 3);
    @(negedge clk);
    start    = 1'b1;
    modeConv = conv;
    wPrec    = 5'(pw);
    aPrec    = 5'(pa);
    jobCount = JOBW'(jobs);
    for (int k = 0; k <= lastK; k++) begin
      @(negedge clk);
      checkCycle(k, conv, jobs, len, tag);
      start = 1'b0;
      if (disturb && k >= 1) begin
        // R7: settings on the ports must be ignored mid-layer
        modeConv = ~conv;
        wPrec    = 5'(17 - pw);
        aPrec    = 5'(17 - pa);
        jobCount = JOBW'(7);
        if (k == 3) start = 1'b1;
      end
      driveCycle(k, conv, pw, pa, jobs, hold, garbage);
    end
  endtask

  task automatic tReset;
    total++;
    if (outValid !== '0) begin
      bad++;
      $display("FAIL R1 reset valid: actual=%0h expected=0", outValid);
    end
    total++;
    if (outData !== '0) begin
      bad++;
      $display("FAIL R1 reset data: actual=nonzero expected=0");
    end
  endtask

  // R3 R4 R8: staggered dense layer, period padded to column count
  task automatic tDenseBasic;
    runLayer(1'b0, 3, 2, 2, 1'b0, 1'b0, 1'b0, "R3 dense padded");
  endtask

  // R3: activation precision above column count sets the period
  task automatic tDenseWide;
    runLayer(1'b0, 2, 7, 2, 1'b0, 1'b0, 1'b0, "R3 dense wide");
  endtask

  // R6: junk on idle weight bus cycles and padded activation steps
  task automatic tDenseGarbage;
    runLayer(1'b0, 4, 1, 3, 1'b1, 1'b0, 1'b0, "R6 masking");
  endtask

  // R5: window mode with shared weights, distinct activations
  task automatic tWindow;
    runLayer(1'b1, 3, 3, 3, 1'b1, 1'b0, 1'b0, "R5 window");
  endtask

  // R8 R9: one-bit jobs finish on consecutive cycles
  task automatic tWindowMin;
    runLayer(1'b1, 1, 1, 4, 1'b0, 1'b0, 1'b0, "R8 back to back");
  endtask

  // R10: widest operands, all ones
  task automatic tFullPrec;
    runLayer(1'b0, 16, 16, 1, 1'b0, 1'b0, 1'b1, "R10 full precision");
  endtask

  // R7: start and setting changes during a layer
  task automatic tBusyStart;
    runLayer(1'b0, 2, 3, 2, 1'b0, 1'b1, 1'b0, "R7 busy start");
  endtask

  // R8: zero jobs yields no result; outputs keep last values
  task automatic tZeroJobs;
    runLayer(1'b1, 2, 2, 0, 1'b1, 1'b0, 1'b0, "R8 zero jobs");
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) lastExp[r][c] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDenseBasic();
    tDenseWide();
    tDenseGarbage();
    tWindow();
    tWindowMin();
    tFullPrec();
    tBusyStart();
    tZeroJobs();
    tWindow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule